// File: doc/BRIEF.md
# Per-CPU Active Priority Tracker

This block follows, for one processor, which preemption levels are currently being serviced and derives the running priority from them. Each acknowledge marks one preemption level as active. Each end-of-interrupt clears that level again, and the running priority falls back to the most urgent level that is still active. The block keeps no list of nested interrupt IDs. Two 128-bit level bitmaps hold the whole nesting state: one bank for secure accesses and one for non-secure accesses.

The end-of-interrupt step can be split in two. A per-security-state mode bit selects the behaviour. With the bit clear, an end-of-interrupt both drops the priority and deactivates the interrupt. With the bit set, it only drops the priority, and a later deactivate write releases the interrupt. The block reports each deactivation as a one-cycle strobe that carries the interrupt ID. The interrupt state logic that follows consumes this strobe.

The event inputs carry a valid bit and have no ready. They are always accepted, so they exert no back-pressure. At most one event is taken per cycle. The deactivate strobe is a valid-only output, and its consumer must take it in the cycle it appears. The bitmaps can be read through a plain combinational read port.

Top module: `apt_tracker`

## Requirements
- R1: After reset both bitmap banks read all zero, the running priority is 0xFF and no deactivate strobe is issued.
- R2: An acknowledge of priority P with binary point B sets preemption index P >> (B+1) in the bitmap. The index sits in word index/32 at bit index%32. The secure bank is used when `sec_i` is 1 and the non-secure bank when it is 0.
- R3: One cycle after an acknowledge, the running priority equals the full 8-bit acknowledged priority.
- R4: An accepted end-of-interrupt with priority P clears index P >> (B+1) in the bank of the current security state. It then loads the running priority with (word*32 + lowest set bit of secure OR non-secure word) << (B+1), keeping the low 8 bits. Words are scanned from 0 upward, and the result is 0xFF when no bit is set in either bank.
- R5: The end-of-interrupt ID is bits [9:0] of the write data, and the higher bits are ignored. An ID of 1020 or above, or an ID not below NUM_IRQ (default 256), changes neither the bitmaps, the running priority nor the strobe.
- R6: An accepted end-of-interrupt whose current-state mode bit is clear emits a deactivate strobe with its ID one cycle later. With the mode bit set, it emits no strobe.
- R7: A deactivate write (ID in bits [9:0]) emits a strobe with that ID one cycle later only when the current-state mode bit is set and the ID is below 1020. Otherwise it has no effect. It never changes the bitmaps or the running priority.
- R8: `sec_i` = 1 selects `eoimode_s_i` and `sec_i` = 0 selects `eoimode_ns_i` as the mode bit for end-of-interrupt and deactivate.
- R9: When events coincide, an acknowledge wins over an end-of-interrupt, which wins over a deactivate write. A losing event is dropped, even if the winning end-of-interrupt is itself ignored.
- R10: `rd_data_o` shows bitmap word `rd_addr_i[1:0]`. It shows the secure bank when `rd_addr_i[2]` is 0 and the non-secure bank when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_i | input | 3 | Binary point |
| sec_i | input | 1 | Current event is a secure access |
| eoimode_s_i | input | 1 | Split end-of-interrupt mode, secure state |
| eoimode_ns_i | input | 1 | Split end-of-interrupt mode, non-secure state |
| ack_valid_i | input | 1 | Acknowledge event |
| ack_prio_i | input | 8 | Priority of acknowledged interrupt |
| eoi_valid_i | input | 1 | End-of-interrupt write |
| eoi_wdata_i | input | 32 | End-of-interrupt write data (ID in [9:0]) |
| eoi_prio_i | input | 8 | Priority of the interrupt being ended |
| dir_valid_i | input | 1 | Deactivate write |
| dir_wdata_i | input | 32 | Deactivate write data (ID in [9:0]) |
| rd_addr_i | input | 3 | Bitmap read select {bank, word} |
| rd_data_o | output | 32 | Selected bitmap word |
| rpr_o | output | 8 | Running priority |
| deact_valid_o | output | 1 | Deactivate strobe |
| deact_id_o | output | 10 | ID being deactivated |

## Verification
Nested acknowledges are mixed across both banks. This shows whether the running priority after a drop is taken from the merged banks and not from one bank alone. It also shows whether the word scan finds the lowest active level when that level is not the most recent one. The same steps run at binary points 0 and 2, which separates a correct index shift and rescale from an off-by-one in the shift amount. End-of-interrupt and deactivate are tried with the mode bit set and clear in each security state, and with IDs that carry high garbage bits, are reserved, or are out of range. These cases reveal a wrongly selected mode bit or ID check. Coincident events show whether the precedence order is kept.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int PRIO_W   = 8;
  localparam int BP_W     = 3;
  localparam int ID_W     = 10;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 4;
  localparam int ID_LIMIT = 1020;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;
endpackage

// File: rtl/apt_preempt_idx.sv
module apt_preempt_idx #(
  parameter int PRIO_W = apt_pkg::PRIO_W,
  parameter int BP_W   = apt_pkg::BP_W,
  parameter int IDX_W  = 7
) (
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [BP_W-1:0]   bp_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [BP_W:0] shamt;
  logic [PRIO_W-1:0] shifted;
  assign shamt   = {1'b0, bp_i} + 1'b1;
  assign shifted = prio_i >> shamt;
  assign idx_o   = IDX_W'(shifted);
endmodule

// File: rtl/apt_lowest_active.sv
module apt_lowest_active #(
  parameter int NWORDS = apt_pkg::NWORDS,
  parameter int WORD_W = apt_pkg::WORD_W,
  parameter int PRIO_W = apt_pkg::PRIO_W,
  parameter int BP_W   = apt_pkg::BP_W
) (
  input  logic [NWORDS*WORD_W-1:0] map_a_i,
  input  logic [NWORDS*WORD_W-1:0] map_b_i,
  input  logic [BP_W-1:0]          bp_i,
  output logic [PRIO_W-1:0]        prio_o
);
  localparam int MAP_W = NWORDS * WORD_W;
  localparam int IDX_W = $clog2(MAP_W);
  localparam int BIT_W = $clog2(WORD_W);

  logic [NWORDS-1:0]       word_hit;
  logic [NWORDS*BIT_W-1:0] low_flat;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] merged;
    logic [BIT_W-1:0]  low;
    assign merged = map_a_i[w*WORD_W +: WORD_W] | map_b_i[w*WORD_W +: WORD_W];
    always_comb begin
      low = '0;
      for (int b = WORD_W - 1; b >= 0; b--)
        if (merged[b]) low = BIT_W'(b);
    end
    assign word_hit[w] = |merged;
    assign low_flat[w*BIT_W +: BIT_W] = low;
  end

  logic             found;
  logic [IDX_W-1:0] idx;
  logic [BP_W:0]    shamt;
  logic [IDX_W+PRIO_W-1:0] scaled;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (!found && word_hit[w]) begin
        found = 1'b1;
        idx   = IDX_W'(w * WORD_W) + IDX_W'(low_flat[w*BIT_W +: BIT_W]);
      end
    end
  end

  assign shamt  = {1'b0, bp_i} + 1'b1;
  assign scaled = {{PRIO_W{1'b0}}, idx} << shamt;
  assign prio_o = found ? scaled[PRIO_W-1:0] : apt_pkg::IDLE_PRIO;
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker #(
  parameter int NUM_IRQ = 256,
  parameter int PRIO_W  = apt_pkg::PRIO_W,
  parameter int BP_W    = apt_pkg::BP_W,
  parameter int ID_W    = apt_pkg::ID_W,
  parameter int WORD_W  = apt_pkg::WORD_W,
  parameter int NWORDS  = apt_pkg::NWORDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BP_W-1:0]           bp_i,
  input  logic                      sec_i,
  input  logic                      eoimode_s_i,
  input  logic                      eoimode_ns_i,
  input  logic                      ack_valid_i,
  input  logic [PRIO_W-1:0]         ack_prio_i,
  input  logic                      eoi_valid_i,
  input  logic [WORD_W-1:0]         eoi_wdata_i,
  input  logic [PRIO_W-1:0]         eoi_prio_i,
  input  logic                      dir_valid_i,
  input  logic [WORD_W-1:0]         dir_wdata_i,
  input  logic [$clog2(NWORDS):0]   rd_addr_i,
  output logic [WORD_W-1:0]         rd_data_o,
  output logic [PRIO_W-1:0]         rpr_o,
  output logic                      deact_valid_o,
  output logic [ID_W-1:0]           deact_id_o
);
  localparam int MAP_W = NWORDS * WORD_W;
  localparam int IDX_W = $clog2(MAP_W);
  localparam int SEL_W = $clog2(NWORDS);

  logic [MAP_W-1:0] map_s_q, map_ns_q, map_s_d, map_ns_d;
  logic [ID_W-1:0]  eoi_id, dir_id;
  logic             mode_sel, eoi_id_ok, dir_id_ok;
  logic             take_ack, take_eoi, take_dir;
  logic [PRIO_W-1:0] sel_prio, drop_prio;
  logic [IDX_W-1:0] lvl_idx;
  logic [MAP_W-1:0] lvl_bit;

  assign eoi_id    = eoi_wdata_i[ID_W-1:0];
  assign dir_id    = dir_wdata_i[ID_W-1:0];
  assign mode_sel  = sec_i ? eoimode_s_i : eoimode_ns_i;
  assign eoi_id_ok = (int'(eoi_id) < apt_pkg::ID_LIMIT) && (int'(eoi_id) < NUM_IRQ);
  assign dir_id_ok = int'(dir_id) < apt_pkg::ID_LIMIT;

  assign take_ack = ack_valid_i;
  assign take_eoi = eoi_valid_i && !ack_valid_i && eoi_id_ok;
  assign take_dir = dir_valid_i && !ack_valid_i && !eoi_valid_i && dir_id_ok && mode_sel;

  assign sel_prio = ack_valid_i ? ack_prio_i : eoi_prio_i;

  apt_preempt_idx #(.PRIO_W(PRIO_W), .BP_W(BP_W), .IDX_W(IDX_W)) u_idx (
    .prio_i (sel_prio),
    .bp_i   (bp_i),
    .idx_o  (lvl_idx)
  );

  assign lvl_bit = MAP_W'(1) << lvl_idx;

  always_comb begin
    map_s_d  = map_s_q;
    map_ns_d = map_ns_q;
    if (take_ack) begin
      if (sec_i) map_s_d  = map_s_q  | lvl_bit;
      else       map_ns_d = map_ns_q | lvl_bit;
    end else if (take_eoi) begin
      if (sec_i) map_s_d  = map_s_q  & ~lvl_bit;
      else       map_ns_d = map_ns_q & ~lvl_bit;
    end
  end

  apt_lowest_active #(.NWORDS(NWORDS), .WORD_W(WORD_W), .PRIO_W(PRIO_W), .BP_W(BP_W)) u_low (
    .map_a_i (map_s_d),
    .map_b_i (map_ns_d),
    .bp_i    (bp_i),
    .prio_o  (drop_prio)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_s_q       <= '0;
      map_ns_q      <= '0;
      rpr_o         <= apt_pkg::IDLE_PRIO;
      deact_valid_o <= 1'b0;
      deact_id_o    <= '0;
    end else begin
      map_s_q       <= map_s_d;
      map_ns_q      <= map_ns_d;
      if (take_ack)      rpr_o <= ack_prio_i;
      else if (take_eoi) rpr_o <= drop_prio;
      deact_valid_o <= take_dir || (take_eoi && !mode_sel);
      if (take_eoi)      deact_id_o <= eoi_id;
      else if (take_dir) deact_id_o <= dir_id;
    end
  end

  logic [SEL_W-1:0] rd_word;
  assign rd_word   = rd_addr_i[SEL_W-1:0];
  assign rd_data_o = rd_addr_i[SEL_W] ? map_ns_q[rd_word*WORD_W +: WORD_W]
                                      : map_s_q[rd_word*WORD_W +: WORD_W];

  // R3
  ack_loads_rpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_i |=> rpr_o == $past(ack_prio_i));

  // R4
  empty_is_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_eoi |=> ((|map_s_q) || (|map_ns_q) || rpr_o == apt_pkg::IDLE_PRIO));

  // R5
  bad_eoi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid_i && !ack_valid_i && !eoi_id_ok) |=>
      (map_s_q == $past(map_s_q) && map_ns_q == $past(map_ns_q) && $stable(rpr_o)));

  // R6
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid_o |-> $past(eoi_valid_i || dir_valid_i));

  // R7
  dir_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid_i && !ack_valid_i && !eoi_valid_i && !mode_sel) |=> !deact_valid_o);

  // R9
  ack_blocks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_i |=> !deact_valid_o);
endmodule

// File: tb/sim_apt_tracker.sv
module sim_apt_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bp = '0;
  logic        sec = 1'b1, ms = 1'b0, mns = 1'b0;
  logic        ack_v = 1'b0, eoi_v = 1'b0, dir_v = 1'b0;
  logic [7:0]  ack_p = '0, eoi_p = '0;
  logic [31:0] eoi_d = '0, dir_d = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  rpr;
  logic        dv;
  logic [9:0]  did;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [127:0] m_s = '0, m_ns = '0;
  logic [7:0]   m_rpr = 8'hFF;
  int exp_q[$];

  always #5 clk = ~clk;

  apt_tracker u0 (
    .clk(clk), .rst_n(rst_n), .bp_i(bp), .sec_i(sec),
    .eoimode_s_i(ms), .eoimode_ns_i(mns),
    .ack_valid_i(ack_v), .ack_prio_i(ack_p),
    .eoi_valid_i(eoi_v), .eoi_wdata_i(eoi_d), .eoi_prio_i(eoi_p),
    .dir_valid_i(dir_v), .dir_wdata_i(dir_d),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rpr_o(rpr), .deact_valid_o(dv), .deact_id_o(did)
  );

  function automatic logic [7:0] model_low();
    for (int i = 0; i < 128; i++)
      if (m_s[i] | m_ns[i]) return 8'((i << (bp + 1)) & 255);
    return 8'hFF;
  endfunction

  // Monitor: pops expected strobes
  always @(negedge clk) begin
    if (rst_n && dv) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6/R7 unexpected strobe id=%0d expected none", did);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(did) != e) begin
          fails++;
          $display("FAIL R6/R7 strobe id actual=%0d expected=%0d", did, e);
        end
      end
    end
  end

  task automatic check_state(string tag);
    checks++;
    if (rpr !== m_rpr) begin
      fails++;
      $display("FAIL %s rpr actual=%h expected=%h", tag, rpr, m_rpr);
    end
    for (int a = 0; a < 8; a++) begin
      logic [31:0] e;
      rd_addr = 3'(a);
      #1;
      e = a[2] ? m_ns[(a%4)*32 +: 32] : m_s[(a%4)*32 +: 32];
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s R10 word %0d actual=%h expected=%h", tag, a, rd_data, e);
      end
    end
  endtask

  // Driver: applies one cycle of events and updates the reference
  task automatic drive(string tag, bit s, bit av, logic [7:0] ap,
                       bit ev, logic [31:0] ed, logic [7:0] ep,
                       bit dvv, logic [31:0] dd);
    int eid, did_i, idx;
    bit mode;
    @(negedge clk);
    sec = s; ack_v = av; ack_p = ap; eoi_v = ev; eoi_d = ed; eoi_p = ep;
    dir_v = dvv; dir_d = dd;
    mode  = s ? ms : mns;
    eid   = int'(ed[9:0]);
    did_i = int'(dd[9:0]);
    if (av) begin
      idx = int'(ap) >> (bp + 1);
      if (s) m_s[idx] = 1'b1; else m_ns[idx] = 1'b1;
      m_rpr = ap;
    end else if (ev) begin
      if (eid < 1020 && eid < 256) begin
        idx = int'(ep) >> (bp + 1);
        if (s) m_s[idx] = 1'b0; else m_ns[idx] = 1'b0;
        m_rpr = model_low();
        if (!mode) exp_q.push_back(eid);
      end
    end else if (dvv) begin
      if (did_i < 1020 && mode) exp_q.push_back(did_i);
    end
    @(negedge clk);
    ack_v = 1'b0; eoi_v = 1'b0; dir_v = 1'b0;
    check_state(tag);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dv !== 1'b0) begin
      fails++;
      $display("FAIL R1 strobe actual=%b expected=0", dv);
    end
    check_state("R1");
    rst_n = 1'b1;

    // binary point 0: nested across banks
    bp = 3'd0;
    drive("R2 R3 secure ack", 1, 1, 8'h40, 0, 0, 0, 0, 0);
    drive("R8 nonsecure ack", 0, 1, 8'h10, 0, 0, 0, 0, 0);
    drive("R2 ack word2",     0, 1, 8'hC2, 0, 0, 0, 0, 0);
    drive("R4 R6 drop ns",    0, 0, 0, 1, 32'd35, 8'h10, 0, 0);
    drive("R5 reserved id",   1, 0, 0, 1, 32'd1023, 8'h40, 0, 0);
    drive("R5 id over count", 1, 0, 0, 1, 32'd300, 8'h40, 0, 0);
    drive("R5 high bits",     1, 0, 0, 1, 32'hFFFF_FC28, 8'h40, 0, 0);
    drive("R4 drop last ns",  0, 0, 0, 1, 32'd97, 8'hC2, 0, 0);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6 pending strobes actual=%0d expected=0", exp_q.size());
    end

    // binary point 2, split mode in secure state
    bp = 3'd2; ms = 1'b1; mns = 1'b0;
    drive("R2 bp2 ack",       1, 1, 8'hB5, 0, 0, 0, 0, 0);
    drive("R3 bp2 nested",    1, 1, 8'h33, 0, 0, 0, 0, 0);
    drive("R6 split drop",    1, 0, 0, 1, 32'd50, 8'h33, 0, 0);
    drive("R7 deactivate",    1, 0, 0, 0, 0, 0, 1, 32'd50);
    drive("R7 R8 ns mode off",0, 0, 0, 0, 0, 0, 1, 32'd51);
    drive("R7 reserved dir",  1, 0, 0, 0, 0, 0, 1, 32'd1021);
    drive("R9 ack over eoi",  1, 1, 8'h08, 1, 32'd60, 8'hB5, 1, 32'd61);
    drive("R9 eoi over dir",  0, 0, 0, 1, 32'd70, 8'h40, 1, 32'd71);
    drive("R9 bad eoi blocks",1, 0, 0, 1, 32'd1022, 8'h08, 1, 32'd72);
    drive("R4 drop s",        1, 0, 0, 1, 32'd80, 8'h08, 0, 0);
    drive("R4 drop to idle",  1, 0, 0, 1, 32'd81, 8'hB5, 0, 0);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 pending strobes actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule